// File: doc/BRIEF.md
# Cartridge HiROM Address Decoder

This block sits between a console's 24-bit cartridge address bus and the memories on a cartridge board built for the high-ROM (mode 21) memory map. The upper address byte is the bank and the lower sixteen bits are the offset inside that bank. Each clock the block samples the bank, the offset and the read and write strobes, and classifies the access as a program ROM read, a save-SRAM read, a save-SRAM write, or an access the cartridge must ignore. On the following cycle it drives the matching chip select, output enable, write enable and physical address.

The program ROM is a 16-bit-wide device, while the console data bus carries one byte per address. The block therefore forms a word address from the low bank bits and the upper offset bits, keeps the lowest offset bit as a lane select, and places the chosen byte on the console read path. Save SRAM is an 8 KiB part with thirteen address lines. Every bank from 0x30 to 0x3F opens the same window at offset 0x6000 to 0x7FFF, so the bank never reaches the SRAM address and each bank in that group mirrors the others.

The control path is a small state machine with five states: `S_IDLE` (no strobe), `S_ROM_READ`, `S_SRAM_READ`, `S_SRAM_WRITE` and `S_BLOCKED`. S_BLOCKED covers an unmapped address, a write into ROM space, and both strobes at once. Every state can move to every state. At each rising edge the next state is taken from the sampled strobes and region, as follows:
- no strobe: idle-entry
- read in ROM space: rom-read-entry
- read in the SRAM window: sram-read-entry
- write in the SRAM window: sram-write-entry
- any other strobe: block-entry

Top module: `hirom_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, rom_cs, rom_oe, sram_cs, sram_oe, sram_we and bus_drive are low and cpu_rdata is 0x00.
- R2: A read (rd_stb=1, wr_stb=0) with bank 0xC0..0xFF and any offset gives rom_cs=1, rom_oe=1 and bus_drive=1 in the next cycle, with all SRAM controls low.
- R3: For a ROM read, rom_addr equals {bank[5:0], offset[15:1]} (21 bits).
- R4: During a ROM read, cpu_rdata equals rom_rdata[7:0] when the sampled offset bit 0 was 0, and rom_rdata[15:8] when it was 1.
- R5: A read with bank 0x30..0x3F and offset 0x6000..0x7FFF gives sram_cs=1, sram_oe=1, sram_we=0 and bus_drive=1, and cpu_rdata equals sram_rdata.
- R6: For any SRAM access, sram_addr equals offset[12:0], whatever bank in 0x30..0x3F was used.
- R7: A write (wr_stb=1, rd_stb=0) into the SRAM window gives sram_cs=1, sram_we=1, sram_oe=0 and bus_drive=0, and sram_wdata equals the sampled cpu_wdata.
- R8: A write into bank 0xC0..0xFF asserts no select, no enable and no bus drive.
- R9: An access outside both regions, and a cycle with no strobe, leaves every select, enable and bus_drive low, and cpu_rdata at 0x00. Boundary cases include offset 0x5FFF or 0x8000 in banks 0x30..0x3F, and banks 0x2F, 0x40 and 0xBF.
- R10: A cycle with both strobes high is treated as an access to nothing, with all outputs as in R9.
- R11: rom_cs and sram_cs are never high together, and sram_oe and sram_we are never high together.
- R12: Outputs always reflect the access sampled at the previous rising edge, and back-to-back accesses to different regions switch in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank | input | 8 | Address bits 23:16 |
| offset | input | 16 | Address bits 15:0 |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| cpu_wdata | input | 8 | Console write data |
| rom_rdata | input | 16 | Word returned by the ROM |
| sram_rdata | input | 8 | Byte returned by the SRAM |
| rom_cs | output | 1 | ROM chip select |
| rom_oe | output | 1 | ROM output enable |
| rom_addr | output | 21 | ROM word address |
| sram_cs | output | 1 | SRAM chip select |
| sram_oe | output | 1 | SRAM output enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 13 | SRAM byte address |
| sram_wdata | output | 8 | Byte written to SRAM |
| cpu_rdata | output | 8 | Byte returned to the console |
| bus_drive | output | 1 | Cartridge drives the console data bus |

## Verification
The bench uses the default parameters: ROM from bank 0xC0 with six bank bits, a 16-bit ROM word, and the SRAM window at banks 0x30..0x3F, offsets 0x6000..0x7FFF. With these values the full 4 MiB ROM span, both byte lanes, and all sixteen mirror banks of the SRAM window can be reached. The edges one step outside each region can also be reached. Random addresses are weighted towards the two regions and their edges, and random strobe pairs exercise every state and transition.

// File: rtl/hirom_pkg.sv
package hirom_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROM_READ,
        S_SRAM_READ,
        S_SRAM_WRITE,
        S_BLOCKED
    } bus_state_e;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_ROM,
        REG_SRAM
    } region_e;

endpackage

// File: rtl/hirom_region_decode.sv
module hirom_region_decode
    import hirom_pkg::*;
#(
    parameter int BANK_W        = 8,
    parameter int OFF_W         = 16,
    parameter int ROM_BANK_MIN  = 8'hC0,
    parameter int SRAM_BANK_MIN = 8'h30,
    parameter int SRAM_BANK_MAX = 8'h3F,
    parameter int SRAM_OFF_MIN  = 16'h6000,
    parameter int SRAM_AW       = 13
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  offset,
    output region_e           region
);
    localparam int SRAM_SPAN    = 1 << SRAM_AW;
    localparam int SRAM_OFF_MAX = SRAM_OFF_MIN + SRAM_SPAN - 1;

    logic in_rom;
    logic in_sram_bank;
    logic in_sram_off;

    always_comb begin
        in_rom       = (int'(bank) >= ROM_BANK_MIN);
        in_sram_bank = (int'(bank) >= SRAM_BANK_MIN) && (int'(bank) <= SRAM_BANK_MAX);
        in_sram_off  = (int'(offset) >= SRAM_OFF_MIN) && (int'(offset) <= SRAM_OFF_MAX);
        if (in_rom)
            region = REG_ROM;
        else if (in_sram_bank && in_sram_off)
            region = REG_SRAM;
        else
            region = REG_NONE;
    end

endmodule

// File: rtl/hirom_bus_fsm.sv
module hirom_bus_fsm
    import hirom_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  region_e           region,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DW-1:0]     wdata,
    output bus_state_e        state,
    output logic [BANK_W-1:0] bank_q,
    output logic [OFF_W-1:0]  offset_q,
    output logic [DW-1:0]     wdata_q
);
    bus_state_e state_nx;

    always_comb begin
        unique case ({rd_stb, wr_stb})
            2'b00: state_nx = S_IDLE;
            2'b11: state_nx = S_BLOCKED;
            2'b10: begin
                unique case (region)
                    REG_ROM:  state_nx = S_ROM_READ;
                    REG_SRAM: state_nx = S_SRAM_READ;
                    default:  state_nx = S_BLOCKED;
                endcase
            end
            default: begin
                if (region == REG_SRAM)
                    state_nx = S_SRAM_WRITE;
                else
                    state_nx = S_BLOCKED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            bank_q   <= '0;
            offset_q <= '0;
            wdata_q  <= '0;
        end else begin
            state <= state_nx;
            if (rd_stb || wr_stb) begin
                bank_q   <= bank;
                offset_q <= offset;
                wdata_q  <= wdata;
            end
        end
    end

endmodule

// File: rtl/hirom_lane_mux.sv
module hirom_lane_mux #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0]                           word,
    input  logic [$clog2(WORD_W/BYTE_W > 1 ? WORD_W/BYTE_W : 2)-1:0] sel,
    output logic [BYTE_W-1:0]                           byte_out
);
    localparam int LANES = WORD_W / BYTE_W;

    logic [BYTE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        byte_out = lanes[0];
        for (int i = 0; i < LANES; i++) begin
            if (int'(sel) == i)
                byte_out = lanes[i];
        end
    end

endmodule

// File: rtl/hirom_decoder.sv
module hirom_decoder
    import hirom_pkg::*;
#(
    parameter int ROM_BANK_MIN  = 8'hC0,
    parameter int ROM_BANK_BITS = 6,
    parameter int ROM_DW        = 16,
    parameter int SRAM_BANK_MIN = 8'h30,
    parameter int SRAM_BANK_MAX = 8'h3F,
    parameter int SRAM_OFF_MIN  = 16'h6000,
    parameter int SRAM_AW       = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bank,
    input  logic [15:0] offset,
    input  logic        rd_stb,
    input  logic        wr_stb,
    input  logic [7:0]  cpu_wdata,
    input  logic [15:0] rom_rdata,
    input  logic [7:0]  sram_rdata,
    output logic        rom_cs,
    output logic        rom_oe,
    output logic [20:0] rom_addr,
    output logic        sram_cs,
    output logic        sram_oe,
    output logic        sram_we,
    output logic [12:0] sram_addr,
    output logic [7:0]  sram_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        bus_drive
);
    localparam int BANK_W = 8;
    localparam int OFF_W  = 16;
    localparam int DW     = 8;
    localparam int LANES  = ROM_DW / DW;
    localparam int LSEL_W = $clog2(LANES > 1 ? LANES : 2);
    localparam int RA_W   = ROM_BANK_BITS + OFF_W - LSEL_W;

    region_e           region;
    bus_state_e        state;
    logic [BANK_W-1:0] bank_q;
    logic [OFF_W-1:0]  offset_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rom_byte;

    hirom_region_decode #(
        .BANK_W        (BANK_W),
        .OFF_W         (OFF_W),
        .ROM_BANK_MIN  (ROM_BANK_MIN),
        .SRAM_BANK_MIN (SRAM_BANK_MIN),
        .SRAM_BANK_MAX (SRAM_BANK_MAX),
        .SRAM_OFF_MIN  (SRAM_OFF_MIN),
        .SRAM_AW       (SRAM_AW)
    ) u_region (
        .bank   (bank),
        .offset (offset),
        .region (region)
    );

    hirom_bus_fsm #(
        .BANK_W (BANK_W),
        .OFF_W  (OFF_W),
        .DW     (DW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .region   (region),
        .bank     (bank),
        .offset   (offset),
        .wdata    (cpu_wdata),
        .state    (state),
        .bank_q   (bank_q),
        .offset_q (offset_q),
        .wdata_q  (wdata_q)
    );

    hirom_lane_mux #(
        .WORD_W (ROM_DW),
        .BYTE_W (DW)
    ) u_lane (
        .word     (rom_rdata),
        .sel      (offset_q[LSEL_W-1:0]),
        .byte_out (rom_byte)
    );

    // Output decode from the registered state
    always_comb begin
        rom_cs     = 1'b0;
        rom_oe     = 1'b0;
        sram_cs    = 1'b0;
        sram_oe    = 1'b0;
        sram_we    = 1'b0;
        bus_drive  = 1'b0;
        cpu_rdata  = '0;
        rom_addr   = RA_W'({bank_q[ROM_BANK_BITS-1:0], offset_q[OFF_W-1:LSEL_W]});
        sram_addr  = offset_q[SRAM_AW-1:0];
        sram_wdata = wdata_q;
        unique case (state)
            S_ROM_READ: begin
                rom_cs    = 1'b1;
                rom_oe    = 1'b1;
                bus_drive = 1'b1;
                cpu_rdata = rom_byte;
            end
            S_SRAM_READ: begin
                sram_cs   = 1'b1;
                sram_oe   = 1'b1;
                bus_drive = 1'b1;
                cpu_rdata = sram_rdata;
            end
            S_SRAM_WRITE: begin
                sram_cs = 1'b1;
                sram_we = 1'b1;
            end
            S_IDLE, S_BLOCKED: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/hirom_decoder_checks.sv
module hirom_decoder_checks #(
    parameter int ROM_BANK_MIN  = 8'hC0,
    parameter int SRAM_BANK_MIN = 8'h30,
    parameter int SRAM_BANK_MAX = 8'h3F,
    parameter int SRAM_OFF_MIN  = 16'h6000,
    parameter int SRAM_AW       = 13
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bank,
    input logic [15:0] offset,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic        rom_cs,
    input logic        rom_oe,
    input logic [20:0] rom_addr,
    input logic        sram_cs,
    input logic        sram_oe,
    input logic        sram_we,
    input logic [12:0] sram_addr,
    input logic        bus_drive
);
    localparam int SRAM_OFF_MAX = SRAM_OFF_MIN + (1 << SRAM_AW) - 1;

    logic hit_rom;
    logic hit_sram;
    assign hit_rom  = int'(bank) >= ROM_BANK_MIN;
    assign hit_sram = int'(bank) >= SRAM_BANK_MIN && int'(bank) <= SRAM_BANK_MAX
                   && int'(offset) >= SRAM_OFF_MIN && int'(offset) <= SRAM_OFF_MAX;

    p_one_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && sram_cs));

    p_oe_we_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_oe && sram_we));

    p_rom_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && hit_rom) |=> (rom_cs && rom_oe && bus_drive && !sram_cs));

    p_rom_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && hit_rom) |=> (rom_addr == {$past(bank[5:0]), $past(offset[15:1])}));

    p_sram_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb ^ wr_stb) && hit_sram) |=> (sram_addr == $past(offset[12:0])));

    p_sram_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rd_stb && hit_sram) |=> (sram_we && sram_cs && !bus_drive));

    p_rom_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && hit_rom) |=> (!rom_cs && !sram_we && !bus_drive));

    p_both_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rd_stb) |=> (!rom_cs && !sram_cs && !bus_drive));

    p_drive_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> (rom_oe || sram_oe));

endmodule

bind hirom_decoder hirom_decoder_checks #(
    .ROM_BANK_MIN  (ROM_BANK_MIN),
    .SRAM_BANK_MIN (SRAM_BANK_MIN),
    .SRAM_BANK_MAX (SRAM_BANK_MAX),
    .SRAM_OFF_MIN  (SRAM_OFF_MIN),
    .SRAM_AW       (SRAM_AW)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank      (bank),
    .offset    (offset),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .rom_cs    (rom_cs),
    .rom_oe    (rom_oe),
    .rom_addr  (rom_addr),
    .sram_cs   (sram_cs),
    .sram_oe   (sram_oe),
    .sram_we   (sram_we),
    .sram_addr (sram_addr),
    .bus_drive (bus_drive)
);

// File: tb/hirom_decoder_test.sv
module hirom_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bank = '0;
    logic [15:0] offset = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [15:0] rom_rdata = '0;
    logic [7:0]  sram_rdata = '0;
    logic        rom_cs, rom_oe, sram_cs, sram_oe, sram_we, bus_drive;
    logic [20:0] rom_addr;
    logic [12:0] sram_addr;
    logic [7:0]  sram_wdata, cpu_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hirom_decoder uut (
        .clk(clk), .rst_n(rst_n), .bank(bank), .offset(offset),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .cpu_wdata(cpu_wdata),
        .rom_rdata(rom_rdata), .sram_rdata(sram_rdata),
        .rom_cs(rom_cs), .rom_oe(rom_oe), .rom_addr(rom_addr),
        .sram_cs(sram_cs), .sram_oe(sram_oe), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .cpu_rdata(cpu_rdata), .bus_drive(bus_drive)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // kind: 0 idle, 1 rom read, 2 sram read, 3 sram write, 4 blocked
    function automatic int exp_kind(input logic [7:0] b, input logic [15:0] o,
                                    input logic r, input logic w);
        bit in_rom  = (b >= 8'hC0);
        bit in_sram = (b >= 8'h30 && b <= 8'h3F && o >= 16'h6000 && o <= 16'h7FFF);
        if (!r && !w) return 0;
        if (r && w) return 4;
        if (r) return in_rom ? 1 : (in_sram ? 2 : 4);
        return in_sram ? 3 : 4;
    endfunction

    function automatic string kind_tag(input int k, input logic [7:0] b,
                                       input logic r, input logic w);
        case (k)
            1: return "R2";
            2: return "R5";
            3: return "R7";
            4: return (r && w) ? "R10" : ((w && b >= 8'hC0) ? "R8" : "R9");
            default: return "R9";
        endcase
    endfunction

    task automatic step(input logic [7:0] b, input logic [15:0] o,
                        input logic r, input logic w, input logic [7:0] wd);
        int k;
        string t;
        logic [7:0] exp_rd;
        bank = b; offset = o; rd_stb = r; wr_stb = w; cpu_wdata = wd;
        rom_rdata = 16'($urandom); sram_rdata = 8'($urandom);
        k = exp_kind(b, o, r, w);
        t = kind_tag(k, b, r, w);
        @(posedge clk);
        @(negedge clk);
        chk(rom_cs == (k == 1) && rom_oe == (k == 1), t, "rom_cs/oe",
            {rom_cs, rom_oe}, {2{k == 1}});
        chk(sram_cs == (k == 2 || k == 3), t, "sram_cs", sram_cs, (k == 2 || k == 3));
        chk(sram_oe == (k == 2) && sram_we == (k == 3), t, "sram_oe/we",
            {sram_oe, sram_we}, {k == 2, k == 3});
        chk(bus_drive == (k == 1 || k == 2), t, "bus_drive", bus_drive, (k == 1 || k == 2));
        chk(!(rom_cs && sram_cs) && !(sram_oe && sram_we), "R11", "exclusive",
            {rom_cs, sram_cs, sram_oe, sram_we}, 0);
        exp_rd = (k == 1) ? (o[0] ? rom_rdata[15:8] : rom_rdata[7:0]) :
                 (k == 2) ? sram_rdata : 8'h00;
        chk(cpu_rdata == exp_rd, (k == 1) ? "R4" : t, "cpu_rdata", cpu_rdata, exp_rd);
        if (k == 1)
            chk(rom_addr == {b[5:0], o[15:1]}, "R3", "rom_addr", rom_addr, {b[5:0], o[15:1]});
        if (k == 2 || k == 3)
            chk(sram_addr == o[12:0], "R6", "sram_addr", sram_addr, o[12:0]);
        if (k == 3)
            chk(sram_wdata == wd, "R7", "sram_wdata", sram_wdata, wd);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        chk(!rom_cs && !rom_oe && !sram_cs && !sram_oe && !sram_we && !bus_drive,
            "R1", "controls in reset", {rom_cs, rom_oe, sram_cs, sram_oe, sram_we, bus_drive}, 0);
        chk(cpu_rdata == 8'h00, "R1", "cpu_rdata in reset", cpu_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rom_cs && !sram_cs && !bus_drive, "R1", "first cycle after reset",
            {rom_cs, sram_cs, bus_drive}, 0);

        // directed corners
        step(8'hC0, 16'h0000, 1, 0, 8'h00);   // R2 lowest ROM
        step(8'hFF, 16'hFFFF, 1, 0, 8'h00);   // R3 R4 highest, high lane
        step(8'hD5, 16'h1234, 1, 0, 8'h00);   // R4 low lane
        step(8'hBF, 16'h0000, 1, 0, 8'h00);   // R9 below ROM
        step(8'h30, 16'h6000, 1, 0, 8'h00);   // R5 window start
        step(8'h3F, 16'h7FFF, 1, 0, 8'h00);   // R6 mirror bank
        step(8'h30, 16'h5FFF, 1, 0, 8'h00);   // R9 below window
        step(8'h3A, 16'h8000, 1, 0, 8'h00);   // R9 above window
        step(8'h2F, 16'h6000, 1, 0, 8'h00);   // R9 bank below
        step(8'h40, 16'h7000, 0, 1, 8'h55);   // R9 bank above, write
        step(8'h35, 16'h6ABC, 0, 1, 8'hA7);   // R7 write
        step(8'hC3, 16'h4000, 0, 1, 8'h99);   // R8 ROM write
        step(8'h31, 16'h6001, 1, 1, 8'h11);   // R10 both strobes
        step(8'hE0, 16'h0101, 0, 0, 8'h00);   // R9 idle
        // R12 back-to-back region switch
        step(8'hC1, 16'h2001, 1, 0, 8'h00);
        bank = 8'h33; offset = 16'h7123; rd_stb = 1; wr_stb = 0;
        @(posedge clk); @(negedge clk);
        chk(sram_cs && !rom_cs, "R12", "switch to SRAM next cycle", {rom_cs, sram_cs}, 2'b01);
        rd_stb = 0;
        @(posedge clk); @(negedge clk);
        chk(!sram_cs && !rom_cs && !bus_drive, "R12", "idle next cycle",
            {rom_cs, sram_cs, bus_drive}, 0);

        for (int i = 0; i < 600; i++) begin
            logic [7:0]  b;
            logic [15:0] o;
            int sel = $urandom_range(0, 3);
            case (sel)
                0: begin b = 8'hC0 | 8'($urandom_range(0, 63)); o = 16'($urandom); end
                1: begin b = 8'h30 | 8'($urandom_range(0, 15)); o = 16'h6000 | 16'($urandom_range(0, 8191)); end
                2: begin
                    b = 8'($urandom_range(0, 1) ? 8'h2F + 8'($urandom_range(0, 17)) : 8'hBF + 8'($urandom_range(0, 1)));
                    o = $urandom_range(0, 1) ? 16'h5FFF + 16'($urandom_range(0, 1)) : 16'h7FFF + 16'($urandom_range(0, 1));
                end
                default: begin b = 8'($urandom); o = 16'($urandom); end
            endcase
            step(b, o, 1'($urandom), 1'($urandom), 8'($urandom));
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule